// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave Engine

This block is the synchronous slave side of a two-wire serial link into a 128 x 8 byte memory. A fast system clock samples the serial clock and data lines. The block finds bus start and stop conditions and collects each transferred byte bit by bit. The first byte after a start is taken as a 7-bit word address followed by a direction bit. No separate select code comes before it.

For a write, each received data byte goes out on a one-cycle strobe with its target address. A commit pulse follows on stop, and a discard pulse follows when a new start cuts the transfer short. The downstream page buffer uses these pulses to hold, commit or drop the bytes. For a read, the engine fetches bytes through a combinational read port. It shifts them out MSB first and steps its address counter each time the master acknowledges.

The engine drives the data line through a pull-low enable only. A busy input from the commit logic stops it from acknowledging address bytes, so a master can poll until the internal write cycle ends.

Top module: `twi_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start condition. From any state it begins address reception. A rising data line while the clock is high is a stop condition. It returns the engine to idle with SDA released until the next start.
- R2: The first byte after a start is sent MSB first. Bits 7 to 1 are the word address, and bit 0 is the direction: 1 selects read, 0 selects write.
- R3: When not busy, the engine acknowledges the address byte by driving sda_pull high for the ninth clock pulse. It does the same for every write data byte, and it releases the line after that pulse.
- R4: Each received write data byte is presented for one cycle on byte_wr, with wr_data and wr_addr. The address then steps its two low bits, which wrap inside the 4-byte page, and keeps its five high bits.
- R5: A stop after at least one write data byte gives one wr_commit pulse. wr_commit and wr_drop never pulse without a preceding data byte, and no two of byte_wr, wr_commit and wr_drop pulse in the same cycle.
- R6: In a read, the engine sends the byte at the current address MSB first. sda_pull changes only while the clock line is low. A master acknowledge (data low on the ninth pulse) makes it send the byte at the next address.
- R7: In a sequential read, the address counter wraps from 127 to 0 and the read goes on.
- R8: After a master non-acknowledge, the engine releases the data line and drives nothing more until the next start.
- R9: While busy_in is high, the engine does not acknowledge an address byte. It then ignores the bus until the next start and produces no byte_wr.
- R10: A start in the middle of any byte aborts the transfer and restarts address reception. If write data bytes were already collected, it gives one wr_drop pulse and no wr_commit.
- R11: After reset, sda_pull is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as read back (wired-AND of all drivers) |
| sda_pull | output | 1 | Active-high enable that pulls the data line low |
| busy_in | input | 1 | Internal write cycle in progress; address bytes get no acknowledge |
| rd_addr | output | 7 | Current word address for the read port |
| rd_data | input | 8 | Memory byte at rd_addr, combinational |
| byte_wr | output | 1 | One-cycle strobe: a write data byte was received |
| wr_addr | output | 7 | Target address of the strobed byte |
| wr_data | output | 8 | Value of the strobed byte |
| wr_commit | output | 1 | One-cycle pulse: write transfer closed by a stop |
| wr_drop | output | 1 | One-cycle pulse: write transfer aborted by a new start |

## Verification
Single-byte writes and reads at fixed addresses check the address and direction split of the first byte. A page write longer than four bytes starting near a page end separates wrap-inside-page from a plain increment. A sequential read running past address 127 separates the full-array wrap from the page wrap. A busy poll, a restart after partly sent write data, a start in the middle of a byte, and a master non-acknowledge followed by an extra clock each show whether the engine leaves the bus and the memory untouched. Seeded random mixes of writes and reads at random addresses and lengths are then compared against a reference image the bench keeps itself.

// File: rtl/twi_pkg.sv
// Shared types for the two-wire byte-memory slave engine.
package twi_pkg;
    // Protocol phase of the slave engine.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // waiting for a start
        ST_RX   = 3'd1,   // shifting in an address or write byte
        ST_ACK  = 3'd2,   // holding the slave acknowledge
        ST_TX   = 3'd3,   // shifting out a read byte
        ST_MACK = 3'd4    // sampling the master acknowledge
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
// Multi-stage synchronizer for a set of asynchronous bus lines.
// Assumes idle-high lines (reset value 1). Also gives the previous
// synchronized sample so a caller can detect edges.
module twi_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] sync,
    output logic [LINES-1:0] prev
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        // Shift the raw line through the flop chain, keeping one more sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
                last  <= chain[STAGES-1];
            end
        end

        assign sync[g] = chain[STAGES-1];
        assign prev[g] = last;
    end
endmodule

// File: rtl/twi_cond_det.sv
// Combinational bus-event decoder working on synchronized samples.
// Assumes both lines went through equal synchronizer depth, so their
// relative order is kept.
module twi_cond_det (
    input  logic scl_s,
    input  logic scl_p,
    input  logic sda_s,
    input  logic sda_p,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    // Decode clock edges and data edges while the clock is held high.
    always_comb begin
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_c  = scl_s & scl_p & sda_p & ~sda_s;
        stop_c   = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/twi_addr_ctr.sv
// Word address counter. It loads from the address byte, steps over the
// whole array for reads, and steps inside a page for writes.
// Assumes at most one command per cycle (load has priority).
module twi_addr_ctr #(
    parameter int AW = 7,
    parameter int PB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_seq,
    input  logic          inc_page,
    output logic [AW-1:0] addr
);
    logic [PB-1:0] lo_next;

    // Low bits advanced with wrap inside the page.
    always_comb lo_next = addr[PB-1:0] + 1'b1;

    // Update the address on load, sequential step or page step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc_seq) begin
            addr <= addr + 1'b1;
        end else if (inc_page) begin
            addr <= {addr[AW-1:PB], lo_next};
        end
    end
endmodule

// File: rtl/twi_mem_slave.sv
// Two-wire slave engine for a byte memory addressed by the first byte.
// The first byte after a start carries the word address (upper bits) and
// the direction (bit 0, 1 = read). Write bytes go out as strobes with
// commit or drop pulses. Read bytes come from a combinational port.
// Assumes clk is at least 8x the serial bit rate, and that rd_data is
// valid in the cycle rd_addr is presented.
module twi_mem_slave
    import twi_pkg::*;
#(
    parameter int BW   = 8,
    parameter int PB   = 2,
    parameter int SYNC = 2,
    localparam int AW  = BW - 1,
    localparam int CW  = $clog2(BW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_pull,
    input  logic          busy_in,
    output logic [AW-1:0] rd_addr,
    input  logic [BW-1:0] rd_data,
    output logic          byte_wr,
    output logic [AW-1:0] wr_addr,
    output logic [BW-1:0] wr_data,
    output logic          wr_commit,
    output logic          wr_drop
);
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    logic [1:0]    ln_sync, ln_prev;
    logic          scl_rise, scl_fall, start_c, stop_c;
    logic          sda_s;
    twi_state_e    state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] sreg;
    logic          is_addr, rw, have_data, got_byte, m_ack;
    logic          byte_end, ld_addr, inc_pg, inc_sq;
    logic [AW-1:0] addr;

    twi_line_sync #(.LINES(2), .STAGES(SYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({scl_in, sda_in}),
        .sync  (ln_sync),
        .prev  (ln_prev)
    );

    assign sda_s = ln_sync[0];

    twi_cond_det u_cond (
        .scl_s    (ln_sync[1]),
        .scl_p    (ln_prev[1]),
        .sda_s    (ln_sync[0]),
        .sda_p    (ln_prev[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    // Counter commands: byte completion and end of a transmitted byte.
    always_comb begin
        byte_end = (state == ST_RX) && scl_fall && got_byte && !start_c && !stop_c;
        ld_addr  = byte_end && is_addr && !busy_in;
        inc_pg   = byte_end && !is_addr;
        inc_sq   = (state == ST_TX) && scl_fall && (cnt == LAST) && !start_c && !stop_c;
    end

    twi_addr_ctr #(.AW(AW), .PB(PB)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld_addr),
        .load_val (sreg[BW-1:1]),
        .inc_seq  (inc_sq),
        .inc_page (inc_pg),
        .addr     (addr)
    );

    assign rd_addr = addr;

    // Protocol sequencer: bus conditions first, then the per-phase bit work.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            sreg      <= '0;
            is_addr   <= 1'b0;
            rw        <= 1'b0;
            have_data <= 1'b0;
            got_byte  <= 1'b0;
            m_ack     <= 1'b0;
            sda_pull  <= 1'b0;
            byte_wr   <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
            wr_drop   <= 1'b0;
        end else begin
            byte_wr   <= 1'b0;
            wr_commit <= 1'b0;
            wr_drop   <= 1'b0;
            if (start_c) begin
                wr_drop   <= have_data;
                have_data <= 1'b0;
                state     <= ST_RX;
                cnt       <= '0;
                is_addr   <= 1'b1;
                got_byte  <= 1'b0;
                sda_pull  <= 1'b0;
            end else if (stop_c) begin
                wr_commit <= have_data;
                have_data <= 1'b0;
                state     <= ST_IDLE;
                got_byte  <= 1'b0;
                sda_pull  <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            sreg <= {sreg[BW-2:0], sda_s};
                            cnt  <= cnt + 1'b1;
                            if (cnt == LAST) got_byte <= 1'b1;
                        end else if (byte_end) begin
                            got_byte <= 1'b0;
                            if (is_addr) begin
                                if (busy_in) begin
                                    state <= ST_IDLE;
                                end else begin
                                    rw       <= sreg[0];
                                    sda_pull <= 1'b1;
                                    state    <= ST_ACK;
                                end
                            end else begin
                                byte_wr   <= 1'b1;
                                wr_addr   <= addr;
                                wr_data   <= sreg;
                                have_data <= 1'b1;
                                sda_pull  <= 1'b1;
                                state     <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt     <= '0;
                            is_addr <= 1'b0;
                            if (rw) begin
                                sreg     <= rd_data;
                                sda_pull <= ~rd_data[BW-1];
                                state    <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == LAST) begin
                                sda_pull <= 1'b0;
                                state    <= ST_MACK;
                            end else begin
                                sreg     <= {sreg[BW-2:0], 1'b0};
                                sda_pull <= ~sreg[BW-2];
                                cnt      <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (m_ack) begin
                                sreg     <= rd_data;
                                sda_pull <= ~rd_data[BW-1];
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/twi_mem_slave_chk.sv
// Protocol checker for twi_mem_slave, attached by bind.
// Assumes the bus keeps the clock low for well over the synchronizer depth.
module twi_mem_slave_chk #(
    parameter int AW = 7,
    parameter int PB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_in,
    input logic          sda_pull,
    input logic          byte_wr,
    input logic [AW-1:0] wr_addr,
    input logic          wr_commit,
    input logic          wr_drop
);
    logic [AW-1:0] prev_addr;
    logic          seen;
    logic [PB-1:0] nxt_lo;

    // Remember the last strobed address within the open write transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr <= '0;
            seen      <= 1'b0;
        end else if (wr_commit || wr_drop) begin
            seen <= 1'b0;
        end else if (byte_wr) begin
            prev_addr <= wr_addr;
            seen      <= 1'b1;
        end
    end

    // Expected low bits of the next address in the page.
    always_comb nxt_lo = prev_addr[PB-1:0] + 1'b1;

    // R6: the data line driver only moves while the clock line is low
    p_pull_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_in);

    // R5: strobes and transfer pulses never coincide
    p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_wr, wr_commit, wr_drop}));

    // R4: consecutive write bytes step inside the page
    p_page_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && seen) |-> (wr_addr == {prev_addr[AW-1:PB], nxt_lo}));

    // R5: a commit follows at least one data byte
    p_commit_has_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> seen);

    // R10: a drop follows at least one data byte
    p_drop_has_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drop |-> seen);
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.AW(AW), .PB(PB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_pull  (sda_pull),
    .byte_wr   (byte_wr),
    .wr_addr   (wr_addr),
    .wr_commit (wr_commit),
    .wr_drop   (wr_drop)
);

// File: tb/twi_mem_slave_test.sv
// Bench for twi_mem_slave: bus master tasks, a device-side memory fed by
// the write strobes, and an independent reference image.
module twi_mem_slave_test;
    localparam int Q = 6;   // system clocks per quarter bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy_in = 1'b0;
    logic       sda_pull;
    logic       sda_bus;
    logic [6:0] rd_addr;
    logic [7:0] rd_data;
    logic       byte_wr, wr_commit, wr_drop;
    logic [6:0] wr_addr;
    logic [7:0] wr_data;

    logic [7:0] dev_mem [128];
    logic [7:0] exp_mem [128];
    logic [6:0] pend_a [32];
    logic [7:0] pend_d [32];
    int         pn = 0;
    int         wr_count = 0, n_commit = 0, n_drop = 0;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;
    logic [7:0] wbuf [16];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;
    assign rd_data = dev_mem[rd_addr];

    twi_mem_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_m),
        .sda_in    (sda_bus),
        .sda_pull  (sda_pull),
        .busy_in   (busy_in),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .byte_wr   (byte_wr),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .wr_drop   (wr_drop)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 37 + 5);
    endfunction

    function automatic logic [6:0] page_addr(input logic [6:0] base, input int i);
        logic [1:0] lo;
        lo = base[1:0] + 2'(i);
        return {base[6:2], lo};
    endfunction

    // Device-side memory: hold strobed bytes, apply on commit, drop on abort.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) dev_mem[i] <= init_val(i);
            pn <= 0;
        end else begin
            if (byte_wr) begin
                pend_a[pn % 32] <= wr_addr;
                pend_d[pn % 32] <= wr_data;
                pn <= pn + 1;
                wr_count <= wr_count + 1;
            end
            if (wr_commit) begin
                for (int i = 0; i < pn && i < 32; i++) dev_mem[pend_a[i]] <= pend_d[i];
                pn <= 0;
                n_commit <= n_commit + 1;
            end
            if (wr_drop) begin
                pn <= 0;
                n_drop <= n_drop + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
        wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        b = sda_bus; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ackb);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(ackb);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(give_ack ? 1'b0 : 1'b1);
    endtask

    function automatic int mem_mismatch();
        int m = 0;
        for (int i = 0; i < 128; i++) if (dev_mem[i] !== exp_mem[i]) m++;
        return m;
    endfunction

    // Full write transfer of n bytes from wbuf, then compare the memories.
    task automatic write_txn(input logic [6:0] a, input int n);
        logic ackb;
        int   nak = 0;
        bus_start();
        send_byte({a, 1'b0}, ackb);
        check(ackb == 1'b0, "R3 R2 address ack on write", ackb, 0);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ackb);
            if (ackb != 1'b0) nak++;
        end
        check(nak == 0, "R3 data byte ack", nak, 0);
        bus_stop();
        wait_q();
        for (int i = 0; i < n; i++) exp_mem[page_addr(a, i)] = wbuf[i];
        check(mem_mismatch() == 0, "R4 R5 memory after write", mem_mismatch(), 0);
    endtask

    // Full read transfer of n bytes with the last one not acknowledged.
    task automatic read_txn(input logic [6:0] a, input int n, input string tag);
        logic       ackb;
        logic [7:0] v;
        int         bad = 0;
        logic [7:0] firstbad = 0, firstexp = 0;
        bus_start();
        send_byte({a, 1'b1}, ackb);
        check(ackb == 1'b0, "R3 R2 address ack on read", ackb, 0);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            if (v !== exp_mem[7'(a + 7'(i))]) begin
                if (bad == 0) begin firstbad = v; firstexp = exp_mem[7'(a + 7'(i))]; end
                bad++;
            end
        end
        check(bad == 0, tag, firstbad, firstexp);
        bus_stop();
    endtask

    initial begin
        int         c0;
        logic       ackb;
        logic       b;
        logic [7:0] v;
        for (int i = 0; i < 128; i++) exp_mem[i] = init_val(i);
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11: idle after reset
        check(sda_pull == 1'b0, "R11 sda_pull after reset", sda_pull, 0);
        check({byte_wr, wr_commit, wr_drop} == 3'b000, "R11 strobes after reset",
              {byte_wr, wr_commit, wr_drop}, 0);

        // R2 R3: single byte write then single byte read
        wbuf[0] = 8'h5A;
        write_txn(7'h21, 1);
        read_txn(7'h21, 1, "R6 single byte read");
        check(n_commit == 1, "R5 one commit for one write", n_commit, 1);

        // R4: six bytes from the end of a page wrap inside it
        for (int i = 0; i < 6; i++) wbuf[i] = 8'h90 + 8'(i);
        write_txn(7'h0E, 6);
        check(exp_mem[7'h0C] == 8'h92 && dev_mem[7'h0C] == 8'h92, "R4 page wrap overwrite",
              dev_mem[7'h0C], 8'h92);
        check(dev_mem[7'h10] == init_val(16), "R4 next page untouched", dev_mem[7'h10], init_val(16));

        // R7: sequential read across 127 to 0
        read_txn(7'h7D, 6, "R7 sequential read wrap");
        read_txn(7'h0C, 4, "R6 sequential read in order");

        // R8: after a non-acknowledge the line stays released
        bus_start();
        send_byte({7'h21, 1'b1}, ackb);
        recv_byte(1'b0, v);
        check(v == exp_mem[7'h21], "R8 byte before nack", v, exp_mem[7'h21]);
        get_bit(b);
        check(b == 1'b1, "R8 line released after nack", b, 1);
        bus_stop();

        // R9: busy blocks the address acknowledge and any write
        c0 = wr_count;
        busy_in = 1'b1;
        bus_start();
        send_byte({7'h30, 1'b0}, ackb);
        check(ackb == 1'b1, "R9 no ack while busy", ackb, 1);
        send_byte(8'hA5, ackb);
        check(ackb == 1'b1, "R9 data ignored while busy", ackb, 1);
        bus_stop();
        busy_in = 1'b0;
        wait_q();
        check(wr_count == c0, "R9 no write strobe while busy", wr_count, c0);
        check(mem_mismatch() == 0, "R9 memory unchanged while busy", mem_mismatch(), 0);

        // R10: restart after collected data drops it
        c0 = n_commit;
        bus_start();
        send_byte({7'h40, 1'b0}, ackb);
        send_byte(8'h11, ackb);
        send_byte(8'h22, ackb);
        bus_start();
        send_byte({7'h40, 1'b1}, ackb);
        check(ackb == 1'b0, "R10 address ack after restart", ackb, 0);
        recv_byte(1'b0, v);
        bus_stop();
        wait_q();
        check(n_drop == 1, "R10 drop pulse on restart", n_drop, 1);
        check(n_commit == c0, "R10 no commit after drop", n_commit, c0);
        check(v == exp_mem[7'h40], "R10 memory kept after drop", v, exp_mem[7'h40]);

        // R10 R1: start in the middle of a byte restarts address reception
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        read_txn(7'h0D, 2, "R10 read after mid-byte start");

        // R1: a stop leaves the engine idle; clocks without a start do nothing
        c0 = wr_count;
        for (int i = 0; i < 9; i++) get_bit(b);
        check(sda_pull == 1'b0 && wr_count == c0, "R1 idle after stop", sda_pull, 0);

        // Seeded random mix of writes and reads
        for (int t = 0; t < 24; t++) begin
            logic [6:0] a;
            int         n;
            a = 7'($urandom);
            if ($urandom % 2 == 0) begin
                n = 1 + int'($urandom % 6);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                write_txn(a, n);
            end else begin
                n = 1 + int'($urandom % 5);
                read_txn(a, n, "R6 R7 random read");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule